// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Aligned Rate Taps

This block turns a stream of input clock ticks into a divided clock whose ratio is a power of two. A 3-bit select code picks the ratio. Next to the main divided output it produces copies at one half and one quarter of the main rate. All three come from the same counter, so their edges line up with the main output's edges. The whole thing runs in one fast clock domain. The input clock is a one-cycle enable `tick_in`, and each output is given both as a one-cycle strobe and as a level waveform.

A new ratio is taken only at the end of a full quarter-rate period. At that point all three outputs begin a period together, so no output is ever cut short. There is no streaming data path. Every pin is a plain control or clock-enable signal with no handshake.

Top module: `pdiv_top`

## Requirements
- R1: While `rst` is high, every bit of `tap_stb` and `tap_clk` is 0 after the next rising clock edge, and the internal position returns to the start of a period.
- R2: With active code M (sel 000..111 meaning ratio 1, 2, 4, 8, 16, 32, 64, 128, i.e. 2^M), `tap_stb[0]` pulses for one cycle, one clock after every tick that starts a main period. A main period is 2^M ticks long.
- R3: `tap_stb[1]` and `tap_stb[2]` pulse in the same way, once every 2·2^M and 4·2^M ticks respectively. Every such pulse coincides with a `tap_stb[0]` pulse, and every `tap_stb[2]` pulse coincides with a `tap_stb[1]` pulse.
- R4: For M ≥ 1, `tap_clk[0]` is high for the first 2^(M-1) ticks of each main period and low for the remaining 2^(M-1), giving a 50% duty cycle counted in ticks.
- R5: For M = 0, `tap_clk[0]` repeats `tick_in` one clock later, so it is high in every cycle that follows a tick.
- R6: `tap_clk[1]` and `tap_clk[2]` are high for the first half of their own periods (2^M and 2·2^M ticks) and low for the second half. Each of their rising edges coincides with a strobe on the same tap.
- R7: `sel_in` is sampled during reset and on the tick that ends a quarter-rate period (4·2^M ticks). A change of `sel_in` at any other time has no effect on the outputs until that boundary.
- R8: In a cycle without `tick_in`, all strobes are 0 one clock later. The position does not advance, and the levels of taps with ratio 2 or more hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Input clock as a one-cycle enable |
| sel_in | input | SEL_W (3) | Ratio code, ratio = 2^code |
| tap_stb | output | TAP_N (3) | Period-start strobes: bit 0 main, bit 1 half rate, bit 2 quarter rate |
| tap_clk | output | TAP_N (3) | Divided clock levels, same bit order |

## Verification
The hardest situation to reach is a ratio change that lands exactly on the quarter-period wrap while a large ratio is active. At ratio 128 that boundary comes only once every 512 ticks. A change made just before it must be ignored, and one held across it must take effect. The stimulus runs a long directed stretch at the largest codes with dense ticks, changing `sel_in` both mid-period and at the wrap. Random segments then mix sparse ticks with frequent code changes at small ratios, so that many boundaries pass with different codes pending.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int DEF_SEL_W = 3;
  localparam int DEF_TAP_N = 3;

  // Counter width able to hold one period of the slowest tap.
  function automatic int span_bits(input int sel_w, input int tap_n);
    return ((1 << sel_w) - 1) + (tap_n - 1);
  endfunction
endpackage

// File: rtl/pdiv_phase.sv
module pdiv_phase #(
  parameter int SEL_W = 3,
  parameter int TAP_N = 3,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel_in,
  output logic [CNT_W-1:0] phase,
  output logic [SEL_W-1:0] sel_act
);
  localparam int KW = $clog2(CNT_W + 1) + 1;

  logic [KW-1:0]  span_k;
  logic [CNT_W:0] span;
  logic [CNT_W:0] last;
  logic           at_wrap;

  always_comb begin
    span_k  = KW'(sel_act) + KW'(TAP_N - 1);
    span    = {{CNT_W{1'b0}}, 1'b1} << span_k;
    last    = span - 1'b1;
    at_wrap = ({1'b0, phase} == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      sel_act <= sel_in;
    end else if (tick) begin
      if (at_wrap) begin
        phase   <= '0;
        sel_act <= sel_in;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdiv_tap.sv
module pdiv_tap #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 9,
  parameter int SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] phase,
  input  logic [SEL_W-1:0] sel_act,
  output logic             stb,
  output logic             lvl
);
  localparam int KW = $clog2(CNT_W + 1) + 1;

  logic [KW-1:0]  k;
  logic [CNT_W:0] mask;
  logic [CNT_W:0] top_bit;
  logic           hit;
  logic           upper_half;
  logic           lvl_next;

  always_comb begin
    k          = KW'(sel_act) + KW'(SHIFT);
    mask       = ({{CNT_W{1'b0}}, 1'b1} << k) - 1'b1;
    top_bit    = mask ^ (mask >> 1);
    hit        = (({1'b0, phase} & mask) == '0);
    upper_half = |({1'b0, phase} & top_bit);
    if (k == '0)
      lvl_next = tick;
    else if (tick)
      lvl_next = ~upper_half;
    else
      lvl_next = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= 1'b0;
      lvl <= 1'b0;
    end else begin
      stb <= tick & hit;
      lvl <= lvl_next;
    end
  end
endmodule

// File: rtl/pdiv_top.sv
module pdiv_top #(
  parameter int SEL_W = pdiv_pkg::DEF_SEL_W,
  parameter int TAP_N = pdiv_pkg::DEF_TAP_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [TAP_N-1:0] tap_stb,
  output logic [TAP_N-1:0] tap_clk
);
  localparam int CNT_W = pdiv_pkg::span_bits(SEL_W, TAP_N);

  logic [CNT_W-1:0] phase;
  logic [SEL_W-1:0] sel_act;

  pdiv_phase #(.SEL_W(SEL_W), .TAP_N(TAP_N), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .tick(tick_in), .sel_in(sel_in),
    .phase(phase), .sel_act(sel_act)
  );

  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    pdiv_tap #(.SEL_W(SEL_W), .CNT_W(CNT_W), .SHIFT(g)) u_tap (
      .clk(clk), .rst(rst), .tick(tick_in), .phase(phase), .sel_act(sel_act),
      .stb(tap_stb[g]), .lvl(tap_clk[g])
    );
  end
endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
  parameter int TAP_N = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_in,
  input logic [TAP_N-1:0] tap_stb,
  input logic [TAP_N-1:0] tap_clk
);
  logic started;
  logic rst_q;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    rst_q   <= rst;
    if (started === 1'b1 && rst_q === 1'b1) begin
      // R1
      reset_clear_chk: assert (tap_stb == '0 && tap_clk == '0)
        else $error("outputs not cleared by reset");
    end
  end

  // R3
  quarter_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    tap_stb[2] |-> (tap_stb[1] && tap_stb[0]));

  // R3
  half_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    tap_stb[1] |-> tap_stb[0]);

  // R8
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> (tap_stb == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> ($stable(tap_clk[1]) && $stable(tap_clk[2])));

  // R6
  half_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_clk[1]) |-> tap_stb[1]);

  // R6
  quarter_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_clk[2]) |-> tap_stb[2]);
endmodule

bind pdiv_top pdiv_chk #(.TAP_N(TAP_N)) u_pdiv_chk (
  .clk(clk), .rst(rst), .tick_in(tick_in), .tap_stb(tap_stb), .tap_clk(tap_clk)
);

// File: tb/test_pdiv_top.sv
module test_pdiv_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [2:0] sel_in = 3'd0;
  logic [2:0] tap_stb;
  logic [2:0] tap_clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int m_pos = 0;
  int m_sel = 0;
  logic [2:0] e_stb = '0;
  logic [2:0] e_clk = '0;

  pdiv_top i_pdiv_top (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sel_in(sel_in),
    .tap_stb(tap_stb), .tap_clk(tap_clk)
  );

  always #2 clk = ~clk;

  task automatic check_bit(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit first_half(input int pos, input int len);
    return (pos % len) < (len / 2);
  endfunction

  task automatic model(input logic r, input logic t, input int s);
    int d;
    if (r) begin
      e_stb = '0; e_clk = '0; m_pos = 0; m_sel = s;
    end else if (t) begin
      d = 1 << m_sel;
      e_stb[0] = (m_pos % d) == 0;
      e_stb[1] = (m_pos % (2 * d)) == 0;
      e_stb[2] = (m_pos % (4 * d)) == 0;
      e_clk[0] = (d == 1) ? 1'b1 : first_half(m_pos, d);
      e_clk[1] = first_half(m_pos, 2 * d);
      e_clk[2] = first_half(m_pos, 4 * d);
      if (m_pos == 4 * d - 1) begin
        m_pos = 0; m_sel = s;
      end else begin
        m_pos++;
      end
    end else begin
      e_stb = '0;
      if (m_sel == 0) e_clk[0] = 1'b0;
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input logic r, input logic t, input logic [2:0] s);
    string lvl_tag;
    rst = r; tick_in = t; sel_in = s;
    lvl_tag = (m_sel == 0) ? "R5" : "R4";
    model(r, t, int'(s));
    @(negedge clk);
    if (r) begin
      check_bit(tap_stb[0] | tap_stb[1] | tap_stb[2] |
                tap_clk[0] | tap_clk[1] | tap_clk[2], 1'b0, "R1");
    end else begin
      check_bit(tap_stb[0], e_stb[0], t ? "R2" : "R8");
      check_bit(tap_stb[1], e_stb[1], t ? "R3" : "R8");
      check_bit(tap_stb[2], e_stb[2], t ? "R3" : "R8");
      check_bit(tap_clk[0], e_clk[0], lvl_tag);
      check_bit(tap_clk[1], e_clk[1], t ? "R6" : "R8");
      check_bit(tap_clk[2], e_clk[2], t ? "R6" : "R8");
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    // R1: reset clears everything and loads the code
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'd3);

    // R7: code change mid-period is ignored until the wrap
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 3'd3);
    step(1'b0, 1'b1, 3'd0);
    check_bit(tap_stb[0], 1'b0, "R7");
    for (int i = 0; i < 26; i++) step(1'b0, 1'b1, 3'd0);
    // wrap tick took code 0: now every tick strobes main
    step(1'b0, 1'b1, 3'd0);
    check_bit(tap_stb[0], 1'b1, "R7");
    check_bit(tap_clk[0], 1'b1, "R5");

    // R5: ratio 1 with a gapped tick pattern
    for (int i = 0; i < 40; i++) step(1'b0, (i % 3) != 0, 3'd0);

    // R2 R4 R7: largest ratios, dense ticks, change near the wrap
    step(1'b1, 1'b0, 3'd7);
    for (int i = 0; i < 1100; i++)
      step(1'b0, 1'b1, (i < 510) ? 3'd7 : 3'd6);
    for (int i = 0; i < 600; i++) step(1'b0, (i % 5) != 4, 3'd6);

    // random mix of sparse ticks and frequent code changes
    for (int i = 0; i < 20000; i++) begin
      logic [2:0] s;
      s = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
      step(($urandom % 4000) == 0, ($urandom % 4) != 0, s);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule